// File: doc/BRIEF.md
# Indexed Colour Lookup Table with RGB Expansion

This block holds a small programmable colour table of sixteen entries, each one byte wide, and turns 4-bit pixel codes into 8-bit-per-channel RGB for a display pipeline. A host loads the table through a pair of byte registers. The first is a control byte whose middle bits select the current entry. The second is a data byte that writes or reads the entry at that selection. The control byte also carries unrelated flag bits, and this block ignores them.

The display side is a separate read port. Each cycle a 4-bit pixel code is looked up. The low six bits of the selected entry hold three 2-bit colour channels, and each channel is scaled to the full 8-bit range. The result is registered, so it appears one cycle after the pixel code. Host writes never stall the display port. A host write and a display lookup of the same entry in the same cycle return the entry's old contents.

Top module: `clut16_rgb`

## Requirements
- R1: While reset is active and right after it, the current index is 0 and the RGB outputs are 0. Entry 0 holds 0x3F (white). Every other entry i holds a grey code: the level L = i*4/16 is placed in each 2-bit channel, giving L*0x15.
- R2: A control-byte write sets the current index to bits 5:2 of the written byte. Bits 7:6 and 1:0 of that byte change neither the index nor any entry.
- R3: With the read select at 0 (control byte), the host read data is 0x00.
- R4: With the read select at 1 (data byte), the host read data is the full 8-bit entry at the current index, bits 7:6 included.
- R5: A data-byte write stores all 8 bits at the current index and leaves every other entry unchanged.
- R6: When a control write and a data write occur in the same cycle, the data goes to the index that was in effect before that cycle. The new index applies from the next cycle.
- R7: One clock after a pixel code is presented, the RGB outputs show the selected entry expanded per channel as 85 times the 2-bit field. Red is bits 1:0, green is bits 3:2 and blue is bits 5:4, so each channel is 0, 85, 170 or 255. Bits 7:6 of the entry have no effect.
- R8: A display lookup of an entry in the same cycle that the host writes that entry yields the old entry. A lookup in the following cycle yields the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ctl_we | input | 1 | Write strobe for the control/index byte |
| host_dat_we | input | 1 | Write strobe for the data byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rd_sel | input | 1 | Read select: 0 = control byte, 1 = data byte |
| host_rdata | output | 8 | Host read data (combinational) |
| pix_code | input | 4 | Pixel code to look up |
| rgb_red | output | 8 | Expanded red, registered |
| rgb_green | output | 8 | Expanded green, registered |
| rgb_blue | output | 8 | Expanded blue, registered |

## Verification
The assertions check the following on every cycle:
- the control read returns zero;
- the index follows the middle bits of each control write and holds otherwise;
- each data write lands at the index that was in effect before the write;
- every RGB output equals the scaled fields of the entry as it stood at the previous edge, which also covers the old-entry result when a write and a lookup collide.

Only the bench scenarios can show the rest:
- the grey reset defaults across the whole table;
- that the flag bits and the top two entry bits really leave the table and the colour unchanged;
- the ordering when a control write and a data write fall in the same cycle.

// File: rtl/clut_pkg.sv
// Package: shared constants and the output pixel type for the colour
// lookup table. Assumes three equal-width colour channels per entry.
package clut_pkg;
    localparam int CLUT_CH_W  = 2;   // bits per channel inside an entry
    localparam int CLUT_OUT_W = 8;   // bits per channel on the display side

    typedef struct packed {
        logic [CLUT_OUT_W-1:0] blue;
        logic [CLUT_OUT_W-1:0] green;
        logic [CLUT_OUT_W-1:0] red;
    } rgb_t;
endpackage

// File: rtl/clut_index.sv
// Module: current-entry index register. Loads the index field, which the
// top has already sliced from the control byte, on a control write.
// Assumes the flag bits never reach this module.
module clut_index #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [IDX_W-1:0] idx_field,
    output logic [IDX_W-1:0] cur_idx
);
    // Hold the index; clear it on reset, load it on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_idx <= '0;
        else if (ctl_we)
            cur_idx <= idx_field;
    end
endmodule

// File: rtl/clut_table.sv
// Module: colour table storage. One register per entry. It has one write
// port, a host read port and a display read port. Reads are combinational,
// so a read at an edge sees the contents from before any write at that edge.
// Assumes N_ENTRIES is a multiple of 4 so the grey defaults spread evenly.
module clut_table #(
    parameter int N_ENTRIES = 16,
    parameter int DATA_W    = 8,
    parameter int CH_W      = 2,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [IDX_W-1:0]            host_idx,
    input  logic [IDX_W-1:0]            disp_idx,
    output logic [DATA_W-1:0]           host_q,
    output logic [DATA_W-1:0]           disp_q,
    output logic [N_ENTRIES*DATA_W-1:0] flat_q
);
    localparam int LEVELS = 1 << CH_W;

    logic [DATA_W-1:0] entry [N_ENTRIES];

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        localparam int LVL = (i == 0) ? (LEVELS - 1) : (i * LEVELS) / N_ENTRIES;
        localparam logic [CH_W-1:0]   LVL_V = CH_W'(LVL);
        localparam logic [DATA_W-1:0] DEF_V = DATA_W'({LVL_V, LVL_V, LVL_V});

        // Per-entry register: grey default on reset, host byte on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[i] <= DEF_V;
            else if (we && (widx == IDX_W'(i)))
                entry[i] <= wdata;
        end

        // Expose the entry for the checker's view of the table.
        assign flat_q[i*DATA_W +: DATA_W] = entry[i];
    end

    // Independent combinational read ports.
    assign host_q = entry[host_idx];
    assign disp_q = entry[disp_idx];
endmodule

// File: rtl/clut_expand.sv
// Module: registered colour expansion. Scales each narrow channel field to
// the full output range and registers the result, giving one cycle of
// latency. Assumes the channels are packed red lowest, then green, then blue.
module clut_expand #(
    parameter int CH_W  = 2,
    parameter int OUT_W = 8,
    localparam int IN_W = 3 * CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   fields,
    output clut_pkg::rgb_t    rgb
);
    localparam int SCALE = ((1 << OUT_W) - 1) / ((1 << CH_W) - 1);

    logic [OUT_W-1:0] chan_q [3];

    for (genvar c = 0; c < 3; c++) begin : g_chan
        logic [OUT_W-1:0] scaled;
        // Scale one channel field to the output width.
        always_comb scaled = OUT_W'(SCALE * int'(fields[c*CH_W +: CH_W]));

        // Register the scaled channel; zero on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chan_q[c] <= '0;
            else
                chan_q[c] <= scaled;
        end
    end

    // Pack the registered channels into the output struct.
    always_comb begin
        rgb.red   = chan_q[0];
        rgb.green = chan_q[1];
        rgb.blue  = chan_q[2];
    end
endmodule

// File: rtl/clut16_rgb.sv
// Module: top of the colour lookup table. The host side has an index/control
// byte and a data byte. The display side has a registered pixel-to-RGB
// lookup. Assumes the host issues at most one access of each kind per cycle.
// A same-cycle data write uses the index from before a same-cycle control write.
module clut16_rgb #(
    parameter int N_ENTRIES = 16,
    parameter int DATA_W    = 8,
    parameter int IDX_LSB   = 2,
    parameter int CH_W      = clut_pkg::CLUT_CH_W,
    parameter int OUT_W     = clut_pkg::CLUT_OUT_W,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ctl_we,
    input  logic              host_dat_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd_sel,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  pix_code,
    output logic [OUT_W-1:0]  rgb_red,
    output logic [OUT_W-1:0]  rgb_green,
    output logic [OUT_W-1:0]  rgb_blue
);
    logic [IDX_W-1:0]            cur_idx;
    logic [DATA_W-1:0]           host_q;
    logic [DATA_W-1:0]           disp_q;
    logic [N_ENTRIES*DATA_W-1:0] tbl_flat;
    clut_pkg::rgb_t              rgb;

    clut_index #(.IDX_W(IDX_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (host_ctl_we),
        .idx_field (host_wdata[IDX_LSB +: IDX_W]),
        .cur_idx   (cur_idx)
    );

    clut_table #(
        .N_ENTRIES (N_ENTRIES),
        .DATA_W    (DATA_W),
        .CH_W      (CH_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (host_dat_we),
        .widx     (cur_idx),
        .wdata    (host_wdata),
        .host_idx (cur_idx),
        .disp_idx (pix_code),
        .host_q   (host_q),
        .disp_q   (disp_q),
        .flat_q   (tbl_flat)
    );

    clut_expand #(.CH_W(CH_W), .OUT_W(OUT_W)) u_expand (
        .clk    (clk),
        .rst_n  (rst_n),
        .fields (disp_q[3*CH_W-1:0]),
        .rgb    (rgb)
    );

    // Host read mux: the control byte reads as zero, the data byte as the entry.
    always_comb host_rdata = host_rd_sel ? host_q : '0;

    // Drive the display outputs from the registered struct.
    always_comb begin
        rgb_red   = rgb.red;
        rgb_green = rgb.green;
        rgb_blue  = rgb.blue;
    end
    // Entry bits above the colour fields do not take part in the expansion.
    logic unused_hi;
    always_comb unused_hi = ^disp_q[DATA_W-1:3*CH_W];
endmodule

// File: rtl/clut16_rgb_chk.sv
// Module: assertion checker for clut16_rgb, bound to the top. It watches the
// host ports, the current index and a flattened view of the table.
module clut16_rgb_chk #(
    parameter int N_ENTRIES = 16,
    parameter int DATA_W    = 8,
    parameter int IDX_LSB   = 2,
    parameter int CH_W      = 2,
    parameter int OUT_W     = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        host_ctl_we,
    input logic                        host_dat_we,
    input logic [DATA_W-1:0]           host_wdata,
    input logic                        host_rd_sel,
    input logic [DATA_W-1:0]           host_rdata,
    input logic [IDX_W-1:0]            pix_code,
    input logic [OUT_W-1:0]            rgb_red,
    input logic [OUT_W-1:0]            rgb_green,
    input logic [OUT_W-1:0]            rgb_blue,
    input logic [IDX_W-1:0]            cur_idx,
    input logic [N_ENTRIES*DATA_W-1:0] tbl_flat
);
    localparam int SCALE = ((1 << OUT_W) - 1) / ((1 << CH_W) - 1);

    logic             live;
    logic [DATA_W-1:0] sel_entry;
    logic [OUT_W-1:0]  exp_r, exp_g, exp_b;

    // Set one cycle after reset so $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // Expected colour for the pixel code presented this cycle.
    always_comb begin
        sel_entry = tbl_flat[pix_code*DATA_W +: DATA_W];
        exp_r = OUT_W'(SCALE * int'(sel_entry[CH_W-1:0]));
        exp_g = OUT_W'(SCALE * int'(sel_entry[2*CH_W-1:CH_W]));
        exp_b = OUT_W'(SCALE * int'(sel_entry[3*CH_W-1:2*CH_W]));
    end

    // R3
    ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_sel |-> host_rdata == '0);

    // R2
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ctl_we |=> cur_idx == $past(host_wdata[IDX_LSB +: IDX_W]));

    // R2
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && !host_ctl_we |=> $stable(cur_idx));

    // R5 R6
    data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_dat_we |=> tbl_flat[$past(cur_idx)*DATA_W +: DATA_W] == $past(host_wdata));

    // R7 R8
    red_expand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> rgb_red == $past(exp_r));

    // R7 R8
    green_expand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> rgb_green == $past(exp_g));

    // R7 R8
    blue_expand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> rgb_blue == $past(exp_b));
endmodule

bind clut16_rgb clut16_rgb_chk #(
    .N_ENTRIES (N_ENTRIES),
    .DATA_W    (DATA_W),
    .IDX_LSB   (IDX_LSB),
    .CH_W      (CH_W),
    .OUT_W     (OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ctl_we (host_ctl_we),
    .host_dat_we (host_dat_we),
    .host_wdata  (host_wdata),
    .host_rd_sel (host_rd_sel),
    .host_rdata  (host_rdata),
    .pix_code    (pix_code),
    .rgb_red     (rgb_red),
    .rgb_green   (rgb_green),
    .rgb_blue    (rgb_blue),
    .cur_idx     (cur_idx),
    .tbl_flat    (tbl_flat)
);

// File: tb/clut16_rgb_tb.sv
// Directed bench for clut16_rgb. Inputs change on the falling edge and
// outputs are sampled on the falling edge.
module clut16_rgb_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_ctl_we = 1'b0;
    logic       host_dat_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_rd_sel = 1'b0;
    logic [7:0] host_rdata;
    logic [3:0] pix_code = '0;
    logic [7:0] rgb_red, rgb_green, rgb_blue;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clut16_rgb u_dut (
        .clk (clk), .rst_n (rst_n),
        .host_ctl_we (host_ctl_we), .host_dat_we (host_dat_we),
        .host_wdata (host_wdata), .host_rd_sel (host_rd_sel),
        .host_rdata (host_rdata), .pix_code (pix_code),
        .rgb_red (rgb_red), .rgb_green (rgb_green), .rgb_blue (rgb_blue)
    );

    function automatic logic [7:0] grey_def(int i);
        int l = (i == 0) ? 3 : (i * 4) / 16;
        return 8'(l * 21);
    endfunction

    function automatic logic [7:0] scale2(logic [1:0] f);
        return 8'(85 * int'(f));
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_index(logic [7:0] ctl);
        host_ctl_we = 1'b1; host_wdata = ctl;
        tick();
        host_ctl_we = 1'b0;
    endtask

    task automatic write_data(logic [7:0] d);
        host_dat_we = 1'b1; host_wdata = d;
        tick();
        host_dat_we = 1'b0;
    endtask

    task automatic read_entry(int idx, string req, logic [7:0] exp);
        set_index(8'(idx << 2));
        host_rd_sel = 1'b1; #1;
        check8(req, host_rdata, exp);
        host_rd_sel = 1'b0;
    endtask

    task automatic check_rgb(string req, logic [7:0] e);
        check8({req, " red"},   rgb_red,   scale2(e[1:0]));
        check8({req, " green"}, rgb_green, scale2(e[3:2]));
        check8({req, " blue"},  rgb_blue,  scale2(e[5:4]));
    endtask

    // R1: outputs cleared in reset and the grey table defaults afterwards.
    task automatic t_reset();
        rst_n = 1'b0; tick(); tick();
        check8("R1 red in reset", rgb_red, 8'h00);
        rst_n = 1'b1; #1;
        host_rd_sel = 1'b1; #1;
        check8("R1 index 0 after reset", host_rdata, 8'h3F);
        host_rd_sel = 1'b0;
        for (int i = 0; i < 16; i++) read_entry(i, "R1 default entry", grey_def(i));
    endtask

    // R2 R3: index from bits 5:2, flag bits ignored, control reads zero.
    task automatic t_index_flags();
        set_index(8'hD7);   // index field 5, flags 11 and 11
        host_rd_sel = 1'b0; #1;
        check8("R3 control reads zero", host_rdata, 8'h00);
        host_rd_sel = 1'b1; #1;
        check8("R2 index from bits 5:2", host_rdata, grey_def(5));
        host_rd_sel = 1'b0;
        read_entry(0, "R2 flags leave entry 0", 8'h3F);
    endtask

    // R4 R5: full byte stored and read back, neighbours untouched.
    task automatic t_write_read();
        set_index(8'(5 << 2));
        write_data(8'hA7);
        host_rd_sel = 1'b1; #1;
        check8("R4 R5 readback", host_rdata, 8'hA7);
        host_rd_sel = 1'b0;
        read_entry(6, "R5 neighbour unchanged", grey_def(6));
        read_entry(4, "R5 neighbour unchanged", grey_def(4));
    endtask

    // R6: same-cycle control and data writes use the old index.
    task automatic t_same_cycle();
        set_index(8'(3 << 2));
        host_ctl_we = 1'b1; host_dat_we = 1'b1; host_wdata = 8'h24; // index field 9
        tick();
        host_ctl_we = 1'b0; host_dat_we = 1'b0;
        host_rd_sel = 1'b1; #1;
        check8("R6 new index holds old default", host_rdata, grey_def(9));
        host_rd_sel = 1'b0;
        read_entry(3, "R6 data at old index", 8'h24);
    endtask

    // R7: pixel expansion with one cycle latency; bits 7:6 ignored.
    task automatic t_pixels();
        pix_code = 4'd5; tick();
        check_rgb("R7 pix5", 8'hA7);
        pix_code = 4'd0; tick();
        check_rgb("R7 pix0 white", 8'h3F);
        pix_code = 4'd1; tick();
        check_rgb("R7 pix1 black", 8'h00);
        pix_code = 4'd10; tick();
        check_rgb("R7 pix10 grey", grey_def(10));
    endtask

    // R8: lookup colliding with a write sees the old entry, then the new one.
    task automatic t_collision();
        set_index(8'(12 << 2));
        pix_code = 4'd12;
        host_dat_we = 1'b1; host_wdata = 8'h06;
        tick();
        host_dat_we = 1'b0;
        check_rgb("R8 old entry on collision", grey_def(12));
        tick();
        check_rgb("R8 new entry next cycle", 8'h06);
    endtask

    initial begin
        t_reset();
        t_index_flags();
        t_write_read();
        t_same_cycle();
        t_pixels();
        t_collision();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule